// File: doc/BRIEF.md
# USB Device Frame and Interrupt Status Unit

This block sits beside the packet decoder of a USB device controller and turns bus-level events into a software-visible interrupt status word. It classifies each decoded start-of-frame token. In full-speed mode every token starts a new frame. In high-speed mode a token that carries the frame number already held is a microframe within that frame, and a token that carries a different number starts a new frame. The block keeps the current frame number and a 3-bit microframe index. A microsecond-tick idle timer watches the J (idle) line state and raises suspend after a programmable span, which is 3 ms by default.

Event status bits are sticky. Software clears them by writing ones into a clear port, and it selects the bits that may drive the single interrupt line through an enable port. The speed flag, the endpoint interrupt inputs and the DMA interrupt inputs are not sticky. They are copied into the status word every cycle. The status word, enable word, frame and microframe numbers and the interrupt line all come straight from registers. Each one reflects, one clock later, the inputs sampled at a rising edge.

Status word layout (width 8+NUM_EP+NUM_DMA): bit 0 speed, bit 1 suspend, bit 2 microframe SOF, bit 3 frame SOF, bit 4 bus reset ended, bit 5 wake-up, bit 6 resume ended, bit 7 upstream resume, bits 8 upward the endpoint inputs, and above them the DMA inputs.

Top module: `usb_frame_stat`

## Requirements
- R1: Status bit 0 follows `hs_mode` one cycle later. A clear write has no effect on it, and it never drives `irq`, even when enable bit 0 is set.
- R2: With `hs_mode` low, every `sof_stb` sets status bit 3 and leaves bit 2 unchanged. It loads `sof_frame` into `frame_num` and holds `uframe_num` at 0.
- R3: With `hs_mode` high, a `sof_stb` whose `sof_frame` equals `frame_num` sets status bit 2 and increments `uframe_num` by one (modulo 8). `frame_num` does not change.
- R4: With `hs_mode` high, a `sof_stb` whose `sof_frame` differs from `frame_num` sets status bit 3, clears `uframe_num` to 0 and loads `frame_num` from `sof_frame`.
- R5: A single `sof_stb` never sets both status bit 2 and status bit 3.
- R6: Status bit 1 (suspend) sets when `line_j` has stayed high for IDLE_US asserted `us_tick` cycles. Any cycle with `line_j` low restarts the count. Suspend sets only once per unbroken J period.
- R7: `rst_end_stb`, `wake_stb`, `rsm_end_stb` and `up_rsm_stb` set status bits 4, 5, 6 and 7 respectively.
- R8: Status bits 1 to 7 stay set until a cycle with `clr_wr` high and a 1 at that bit position of `clr_data`. That write clears the bit.
- R9: If a clear and a new event hit the same bit in the same cycle, the bit stays set.
- R10: `irq` is high exactly when some status bit at position 1 or above is set together with the same bit of `ien_word`. `ien_word` loads `ien_data` when `ien_wr` is high.
- R11: `ep_irq` appears at status bits starting at 8 and `dma_irq` at bits starting at 8+NUM_EP. Both are copied each cycle and are not sticky.
- R12: After reset, the status word, `ien_word`, `frame_num`, `uframe_num` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hs_mode | input | 1 | 1 = high-speed operation |
| sof_stb | input | 1 | Decoded SOF token strobe |
| sof_frame | input | 11 | Frame number carried by the SOF token |
| line_j | input | 1 | Bus is in the J (idle) state |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| rst_end_stb | input | 1 | Bus reset has ended |
| wake_stb | input | 1 | Wake-up detected |
| rsm_end_stb | input | 1 | Resume has ended |
| up_rsm_stb | input | 1 | Upstream resume sent |
| ep_irq | input | NUM_EP | Endpoint interrupt inputs, copied through |
| dma_irq | input | NUM_DMA | DMA interrupt inputs, copied through |
| clr_wr | input | 1 | Clear-register write strobe |
| clr_data | input | 8+NUM_EP+NUM_DMA | Write-one-to-clear mask |
| ien_wr | input | 1 | Enable-register write strobe |
| ien_data | input | 8+NUM_EP+NUM_DMA | New enable word |
| stat_word | output | 8+NUM_EP+NUM_DMA | Interrupt status word |
| ien_word | output | 8+NUM_EP+NUM_DMA | Current enable word |
| frame_num | output | 11 | Current frame number |
| uframe_num | output | 3 | Current microframe index |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with IDLE_US = 20, NUM_EP = 3 and NUM_DMA = 2, which gives a 13-bit status word. The short idle span puts the exact suspend threshold within a few dozen cycles. At that span the bench can check the last quiet cycle, the setting cycle, the single-shot behaviour under a long J period and the restart after a break. The small endpoint and DMA counts place both copied fields, and the boundary between them, inside a word that the bench checks bit by bit.

// File: rtl/usbfs_pkg.sv
package usbfs_pkg;
  localparam int B_SPEED  = 0;
  localparam int B_SUSP   = 1;
  localparam int B_USOF   = 2;
  localparam int B_SOF    = 3;
  localparam int B_RSTEND = 4;
  localparam int B_WAKE   = 5;
  localparam int B_RSMEND = 6;
  localparam int B_UPRSM  = 7;
  localparam int FIX_BITS = 8;
  localparam int FRAME_W  = 11;
  localparam int MICRO_W  = 3;
endpackage

// File: rtl/fstat_sof_track.sv
module fstat_sof_track
  import usbfs_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sof_stb,
  input  logic [FRAME_W-1:0] sof_frame,
  input  logic               hs_mode,
  output logic               ev_micro,
  output logic               ev_frame,
  output logic [FRAME_W-1:0] frame_q,
  output logic [MICRO_W-1:0] micro_q
);
  logic same_frame;

  always_comb begin
    same_frame = (sof_frame == frame_q);
    ev_micro   = sof_stb && hs_mode && same_frame;
    ev_frame   = sof_stb && !(hs_mode && same_frame);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      micro_q <= '0;
    end else if (ev_frame) begin
      frame_q <= sof_frame;
      micro_q <= '0;
    end else if (ev_micro) begin
      micro_q <= micro_q + 1'b1;
    end else if (!hs_mode) begin
      micro_q <= '0;
    end
  end

  AST_SOF_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ev_micro && ev_frame)); // R5
  AST_FS_MICRO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sof_stb && !hs_mode) |=> (micro_q == '0)); // R2
  AST_USOF_HOLD: assert property (@(posedge clk) disable iff (rst)
    ev_micro |=> ($stable(frame_q) && (micro_q == MICRO_W'($past(micro_q) + 1'b1)))); // R3
  AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (rst)
    ev_frame |=> ((frame_q == $past(sof_frame)) && (micro_q == '0))); // R4
endmodule

// File: rtl/fstat_idle_timer.sv
module fstat_idle_timer #(
  parameter int IDLE_US = 3000
) (
  input  logic clk,
  input  logic rst,
  input  logic line_j,
  input  logic us_tick,
  output logic susp_ev
);
  localparam int CW = $clog2(IDLE_US + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_US - 1);

  logic [CW-1:0] cnt;
  logic          fired;

  always_comb begin
    susp_ev = line_j && us_tick && !fired && (cnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst || !line_j) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (us_tick && !fired) begin
      if (cnt == LAST) fired <= 1'b1;
      else             cnt   <= cnt + 1'b1;
    end
  end

  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (rst)
    !line_j |=> ((cnt == '0) && !fired)); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R6
endmodule

// File: rtl/fstat_irq_reg.sv
module fstat_irq_reg
  import usbfs_pkg::*;
#(
  parameter int SW = 21
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] set_vec,
  input  logic [SW-1:0] live_vec,
  input  logic          clr_wr,
  input  logic [SW-1:0] clr_data,
  input  logic          ien_wr,
  input  logic [SW-1:0] ien_data,
  output logic [SW-1:0] stat_q,
  output logic [SW-1:0] ien_q,
  output logic          irq_q
);
  localparam logic [SW-1:0] EV_MASK  = {{(SW-FIX_BITS){1'b0}}, 8'hFE};
  localparam logic [SW-1:0] IRQ_MASK = {{(SW-1){1'b1}}, 1'b0};

  logic [SW-1:0] clr_eff, stat_next, ien_next, keep_v, set_ev;
  logic          irq_next;

  always_comb begin
    clr_eff   = clr_wr ? clr_data : '0;
    set_ev    = set_vec & EV_MASK;
    keep_v    = stat_q & EV_MASK & ~clr_eff;
    stat_next = keep_v | set_ev | (live_vec & ~EV_MASK);
    ien_next  = ien_wr ? ien_data : ien_q;
    irq_next  = |(stat_next & ien_next & IRQ_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      ien_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_next;
      ien_q  <= ien_next;
      irq_q  <= irq_next;
    end
  end

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(keep_v)) == $past(keep_v))); // R8
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(set_ev)) == $past(set_ev))); // R9
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(stat_q & ien_q & IRQ_MASK)); // R10
endmodule

// File: rtl/usb_frame_stat.sv
module usb_frame_stat
  import usbfs_pkg::*;
#(
  parameter int NUM_EP  = 7,
  parameter int NUM_DMA = 6,
  parameter int IDLE_US = 3000,
  localparam int SW     = FIX_BITS + NUM_EP + NUM_DMA
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hs_mode,
  input  logic               sof_stb,
  input  logic [FRAME_W-1:0] sof_frame,
  input  logic               line_j,
  input  logic               us_tick,
  input  logic               rst_end_stb,
  input  logic               wake_stb,
  input  logic               rsm_end_stb,
  input  logic               up_rsm_stb,
  input  logic [NUM_EP-1:0]  ep_irq,
  input  logic [NUM_DMA-1:0] dma_irq,
  input  logic               clr_wr,
  input  logic [SW-1:0]      clr_data,
  input  logic               ien_wr,
  input  logic [SW-1:0]      ien_data,
  output logic [SW-1:0]      stat_word,
  output logic [SW-1:0]      ien_word,
  output logic [FRAME_W-1:0] frame_num,
  output logic [MICRO_W-1:0] uframe_num,
  output logic               irq
);
  logic          ev_micro, ev_frame, susp_ev;
  logic [SW-1:0] set_vec, live_vec;

  fstat_sof_track u_sof (
    .clk(clk), .rst(rst), .sof_stb(sof_stb), .sof_frame(sof_frame),
    .hs_mode(hs_mode), .ev_micro(ev_micro), .ev_frame(ev_frame),
    .frame_q(frame_num), .micro_q(uframe_num)
  );

  fstat_idle_timer #(.IDLE_US(IDLE_US)) u_idle (
    .clk(clk), .rst(rst), .line_j(line_j), .us_tick(us_tick), .susp_ev(susp_ev)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[B_SUSP]   = susp_ev;
    set_vec[B_USOF]   = ev_micro;
    set_vec[B_SOF]    = ev_frame;
    set_vec[B_RSTEND] = rst_end_stb;
    set_vec[B_WAKE]   = wake_stb;
    set_vec[B_RSMEND] = rsm_end_stb;
    set_vec[B_UPRSM]  = up_rsm_stb;
    live_vec          = '0;
    live_vec[B_SPEED] = hs_mode;
    live_vec[FIX_BITS +: NUM_EP]           = ep_irq;
    live_vec[FIX_BITS + NUM_EP +: NUM_DMA] = dma_irq;
  end

  fstat_irq_reg #(.SW(SW)) u_reg (
    .clk(clk), .rst(rst), .set_vec(set_vec), .live_vec(live_vec),
    .clr_wr(clr_wr), .clr_data(clr_data), .ien_wr(ien_wr), .ien_data(ien_data),
    .stat_q(stat_word), .ien_q(ien_word), .irq_q(irq)
  );

  AST_SPEED_MIRROR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stat_word[B_SPEED] == $past(hs_mode))); // R1
  AST_PASS_EP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stat_word[FIX_BITS +: NUM_EP] == $past(ep_irq))); // R11
  AST_PASS_DMA: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stat_word[FIX_BITS + NUM_EP +: NUM_DMA] == $past(dma_irq))); // R11
endmodule

// File: tb/sim_usb_frame_stat.sv
module sim_usb_frame_stat;
  localparam int NUM_EP = 3, NUM_DMA = 2, IDLE_US = 20;
  localparam int SW = 8 + NUM_EP + NUM_DMA;

  logic clk = 1'b0, rst = 1'b1;
  logic hs_mode = 0, sof_stb = 0, line_j = 0, us_tick = 0;
  logic rst_end_stb = 0, wake_stb = 0, rsm_end_stb = 0, up_rsm_stb = 0;
  logic [10:0] sof_frame = '0;
  logic [NUM_EP-1:0] ep_irq = '0;
  logic [NUM_DMA-1:0] dma_irq = '0;
  logic clr_wr = 0, ien_wr = 0;
  logic [SW-1:0] clr_data = '0, ien_data = '0;
  logic [SW-1:0] stat_word, ien_word;
  logic [10:0] frame_num;
  logic [2:0] uframe_num;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  usb_frame_stat #(.NUM_EP(NUM_EP), .NUM_DMA(NUM_DMA), .IDLE_US(IDLE_US)) u0 (
    .clk(clk), .rst(rst), .hs_mode(hs_mode), .sof_stb(sof_stb), .sof_frame(sof_frame),
    .line_j(line_j), .us_tick(us_tick), .rst_end_stb(rst_end_stb), .wake_stb(wake_stb),
    .rsm_end_stb(rsm_end_stb), .up_rsm_stb(up_rsm_stb), .ep_irq(ep_irq), .dma_irq(dma_irq),
    .clr_wr(clr_wr), .clr_data(clr_data), .ien_wr(ien_wr), .ien_data(ien_data),
    .stat_word(stat_word), .ien_word(ien_word), .frame_num(frame_num),
    .uframe_num(uframe_num), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sof(input logic [10:0] fr);
    sof_stb = 1; sof_frame = fr;
    @(negedge clk); sof_stb = 0;
  endtask

  task automatic clear(input logic [SW-1:0] m);
    clr_wr = 1; clr_data = m;
    @(negedge clk); clr_wr = 0; clr_data = '0;
  endtask

  task automatic set_ien(input logic [SW-1:0] m);
    ien_wr = 1; ien_data = m;
    @(negedge clk); ien_wr = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R12 status", 32'(stat_word), 0);
    check("R12 enable", 32'(ien_word), 0);
    check("R12 frame", 32'({frame_num, uframe_num}), 0);
    check("R12 irq", 32'(irq), 0);
  endtask

  task automatic t_fullspeed();
    hs_mode = 0;
    sof(11'd5);
    check("R2 sof bit", 32'(stat_word[3:2]), 32'b10);
    check("R2 frame", 32'(frame_num), 5);
    clear('1);
    sof(11'd5);
    check("R2 same frame still frame SOF", 32'(stat_word[3:2]), 32'b10);
    check("R2 micro zero", 32'(uframe_num), 0);
    clear('1);
  endtask

  task automatic t_highspeed();
    hs_mode = 1;
    sof(11'd9);
    check("R4 frame SOF", 32'(stat_word[3:2]), 32'b10);
    check("R4 frame load", 32'({frame_num, uframe_num}), {11'd9, 3'd0});
    clear(13'b1100);
    sof(11'd9);
    check("R3 micro SOF", 32'(stat_word[3:2]), 32'b01);
    check("R5 one bit only", 32'(stat_word[3]), 0);
    sof(11'd9); sof(11'd9);
    check("R3 micro count", 32'({frame_num, uframe_num}), {11'd9, 3'd3});
    repeat (5) sof(11'd9);
    check("R3 micro wrap", 32'(uframe_num), 0);
    clear(13'b1100);
    sof(11'd10);
    check("R4 new frame", 32'({stat_word[3:2], frame_num, uframe_num}), {2'b10, 11'd10, 3'd0});
    clear('1);
    check("R1 speed not cleared", 32'(stat_word[0]), 1);
    check("R8 events cleared", 32'(stat_word[7:1]), 0);
  endtask

  task automatic t_events();
    rst_end_stb = 1; wake_stb = 1; rsm_end_stb = 1; up_rsm_stb = 1;
    @(negedge clk);
    rst_end_stb = 0; wake_stb = 0; rsm_end_stb = 0; up_rsm_stb = 0;
    check("R7 event bits", 32'(stat_word[7:4]), 32'hF);
    repeat (3) @(negedge clk);
    check("R8 sticky", 32'(stat_word[7:4]), 32'hF);
    clear(13'b0010_0000);
    check("R8 single clear", 32'(stat_word[7:4]), 32'b1101);
    clr_wr = 1; clr_data = 13'b1_0000; rst_end_stb = 1;
    @(negedge clk);
    clr_wr = 0; clr_data = '0; rst_end_stb = 0;
    check("R9 event wins", 32'(stat_word[4]), 1);
    clear('1);
  endtask

  task automatic t_irq();
    set_ien(13'b1);
    check("R1 speed no irq", 32'({stat_word[0], irq}), 32'b10);
    set_ien(13'b1_0000);
    check("R10 no irq idle", 32'(irq), 0);
    rst_end_stb = 1; @(negedge clk); rst_end_stb = 0;
    check("R10 irq on enabled bit", 32'(irq), 1);
    clear(13'b1_0000);
    check("R10 irq drop", 32'(irq), 0);
    ep_irq = 3'b001; dma_irq = 2'b10;
    @(negedge clk);
    check("R11 pass bits", 32'(stat_word[12:8]), 32'b10_001);
    check("R10 unenabled no irq", 32'(irq), 0);
    set_ien(13'h100);
    check("R10 ep irq", 32'(irq), 1);
    clear('1);
    check("R11 not cleared", 32'(stat_word[8]), 1);
    ep_irq = '0; dma_irq = '0;
    @(negedge clk);
    check("R11 follows input", 32'({stat_word[12:8], irq}), 0);
    set_ien('0);
  endtask

  task automatic t_idle();
    line_j = 1; us_tick = 1;
    repeat (IDLE_US - 1) @(negedge clk);
    check("R6 before threshold", 32'(stat_word[1]), 0);
    @(negedge clk);
    check("R6 at threshold", 32'(stat_word[1]), 1);
    clear(13'b10);
    repeat (3 * IDLE_US) @(negedge clk);
    check("R6 once per period", 32'(stat_word[1]), 0);
    line_j = 0; @(negedge clk); line_j = 1;
    repeat (IDLE_US - 1) @(negedge clk);
    check("R6 restart count", 32'(stat_word[1]), 0);
    @(negedge clk);
    check("R6 second period", 32'(stat_word[1]), 1);
    line_j = 0; us_tick = 0;
    clear('1);
  endtask

  initial begin
    t_reset();
    t_fullspeed();
    t_highspeed();
    t_events();
    t_irq();
    t_idle();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule